// File: doc/BRIEF.md
# External SRAM Bus Cycle Generator

This block turns single requests from an internal port into one external bus cycle for one chip-select area of an asynchronous SRAM-style local bus. A request carries an address, write data, byte enables and a read/write flag. The block accepts it only when it is idle and when address bits 28 to 26 match the area code. It then steps through a setup phase, a strobe phase, an optional extension by the external ready pin, and a hold phase. During these phases it drives chip-select, the read strobe (which doubles as output enable), four byte-lane write strobes, a bus-start pulse, and the address and data pins.

Per-area configuration inputs set the bus width (8, 16 or 32 bits), the address-to-strobe setup (0 to 7 cycles), the strobe-to-deselect hold (0 to 7 cycles), the number of inserted wait cycles (0 to 25) and a one-cycle bus-start hold. These inputs are captured when a request is accepted. When the access ends, the block returns right-aligned read data and a one-cycle done pulse. Each request produces exactly one external cycle. Wide transfers are never split.

Top module: `sram_cycle_gen`

## Requirements
- R1: After reset, cs_n_o, rd_n_o and bs_n_o are 1, we_n_o is 4'hF, rsp_done_o is 0 and req_ready_o is 1.
- R2: A request is accepted only when req_ready_o is 1 and req_addr_i[28:26] equals AREA_CODE (default 3'b110). A request with any other area code causes no chip-select and no done pulse.
- R3: cs_n_o is low from the cycle after acceptance until the last hold cycle. The length is setup + strobe + hold cycles. req_ready_o is low for exactly those cycles. When cs_n_o is high, no strobe is active.
- R4: The strobe starts after the programmed setup count of 0 to 7 cycles. A read drives rd_n_o low. A write drives we_n_o to ~(be & lane_mask). Bus width code 0 means 8 bits with lane_mask 4'b0001, code 1 means 16 bits with lane_mask 4'b0011, and codes 2 and 3 mean 32 bits with lane_mask 4'b1111. Read and write strobes are never active together.
- R5: The strobe lasts 1 + W cycles, where W is the wait count of 0 to 25. A programmed value above 25 acts as 25.
- R6: ext_ready_i is sampled on the last wait cycle and on every extension cycle. Each sample of 0 adds one strobe cycle. With W = 0 the pin is ignored and the strobe lasts one cycle.
- R7: After the strobe ends, chip-select stays low for the hold count of 0 to 7 cycles.
- R8: bs_n_o is low in the first bus cycle. When bus-start hold is set and setup is 1 or more, it stays low for a second cycle. In all other cases it is low for one cycle only.
- R9: Read data is captured at the end of the final strobe cycle and masked to the bus width, right-aligned. During a write access, data_oe_o is 1 and data_o carries the write data.
- R10: rsp_done_o is high for exactly one cycle, the cycle after the last bus cycle. A request with setup 0, wait 0 and hold 0 therefore completes in the second cycle after acceptance.
- R11: Configuration is captured at acceptance. Changing the configuration inputs during an access does not alter that access's timing or lane mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, able to accept |
| req_addr_i | input | AW | Request physical address |
| req_wdata_i | input | 32 | Write data, right-aligned for narrow buses |
| req_be_i | input | 4 | Byte enables |
| req_write_i | input | 1 | 1 = write, 0 = read |
| cfg_width_i | input | 2 | Bus width code (0: 8, 1: 16, 2/3: 32) |
| cfg_setup_i | input | 3 | Setup cycles before strobe |
| cfg_hold_i | input | 3 | Hold cycles after strobe |
| cfg_wait_i | input | 5 | Inserted wait cycles (clamped to 25) |
| cfg_bs_hold_i | input | 1 | Extend bus-start by one cycle |
| ext_ready_i | input | 1 | External ready, low extends strobe |
| cs_n_o | output | 1 | Area chip-select, active low |
| rd_n_o | output | 1 | Read strobe / output enable, active low |
| we_n_o | output | 4 | Byte-lane write strobes, active low |
| bs_n_o | output | 1 | Bus-start, active low |
| addr_o | output | AW | Address pins |
| data_o | output | 32 | Write data pins |
| data_oe_o | output | 1 | Data pin drive enable |
| data_i | input | 32 | Read data pins |
| rsp_rdata_o | output | 32 | Captured read data |
| rsp_done_o | output | 1 | Access complete pulse |

## Verification
Every bus output is a decode of registered state. It therefore changes one cycle after the edge that accepts a request or advances a phase. The first bus cycle is cycle 1 after acceptance, the strobe begins in cycle setup+1, and rsp_done_o and rsp_rdata_o are valid in cycle setup+strobe+hold+1. The bench samples at the falling edge of each cycle after acceptance and numbers those cycles. It also drives ext_ready_i at that falling edge from the strobe count seen so far, so the pin is steady at the sampling edge. It then compares the observed cycle indices and counts with those formulas.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic [1:0] width;
    logic [2:0] setup;
    logic [2:0] hold;
    logic [4:0] waits;
    logic       bs_hold;
  } area_cfg_t;

  function automatic logic [3:0] lane_mask(input logic [1:0] width);
    case (width)
      2'd0:    lane_mask = 4'b0001;
      2'd1:    lane_mask = 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/sram_cyc_seq.sv
module sram_cyc_seq
  import sram_cyc_pkg::*;
#(
  parameter int unsigned CW       = 5,
  parameter int unsigned MAX_WAIT = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    start_setup_i,
  input  logic          start_bs_hold_i,
  input  logic [CW-1:0] start_waits_i,
  input  logic [CW-1:0] waits_q_i,
  input  logic [2:0]    hold_q_i,
  input  logic          ext_ready_i,
  output phase_e        phase_o,
  output logic          capture_o,
  output logic          bs_active_o,
  output logic          done_o
);
  phase_e        phase_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    bs_left_q;
  logic          done_q;
  logic          strobe_end;

  // strobe leaves when counter expired and ready seen (ready ignored with zero waits)
  assign strobe_end  = (phase_q == PH_STROBE) && (cnt_q == '0) &&
                       ((waits_q_i == '0) || ext_ready_i);
  assign capture_o   = strobe_end;
  assign bs_active_o = (phase_q != PH_IDLE) && (bs_left_q != 2'd0);
  assign phase_o     = phase_q;
  assign done_o      = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      bs_left_q <= 2'd0;
      done_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q != PH_IDLE && bs_left_q != 2'd0) bs_left_q <= bs_left_q - 2'd1;
      case (phase_q)
        PH_IDLE: if (start_i) begin
          bs_left_q <= (start_bs_hold_i && start_setup_i != 3'd0) ? 2'd2 : 2'd1;
          if (start_setup_i != 3'd0) begin
            phase_q <= PH_SETUP;
            cnt_q   <= CW'(start_setup_i) - CW'(1);
          end else begin
            phase_q <= PH_STROBE;
            cnt_q   <= start_waits_i;
          end
        end
        PH_SETUP: begin
          if (cnt_q == '0) begin
            phase_q <= PH_STROBE;
            cnt_q   <= waits_q_i;
          end else cnt_q <= cnt_q - CW'(1);
        end
        PH_STROBE: begin
          if (strobe_end) begin
            if (hold_q_i != 3'd0) begin
              phase_q <= PH_HOLD;
              cnt_q   <= CW'(hold_q_i) - CW'(1);
            end else begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end
          end else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
        end
        PH_HOLD: begin
          if (cnt_q == '0) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else cnt_q <= cnt_q - CW'(1);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE) |-> (cnt_q <= CW'(MAX_WAIT)));
  p_ready_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STROBE && cnt_q == '0 && waits_q_i == '0) |=> (phase_q != PH_STROBE));
  p_done_in_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (phase_q == PH_IDLE));
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/sram_cyc_lanes.sv
module sram_cyc_lanes
  import sram_cyc_pkg::*;
(
  input  phase_e      phase_i,
  input  logic        write_i,
  input  logic [3:0]  be_i,
  input  logic [1:0]  width_i,
  input  logic [31:0] pin_data_i,
  output logic        rd_n_o,
  output logic [3:0]  we_n_o,
  output logic [31:0] rdata_o
);
  logic [3:0] mask;
  logic       strobe;

  assign mask   = lane_mask(width_i);
  assign strobe = (phase_i == PH_STROBE);
  assign rd_n_o = !(strobe && !write_i);
  assign we_n_o = (strobe && write_i) ? ~(be_i & mask) : 4'hF;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign rdata_o[8*g +: 8] = mask[g] ? pin_data_i[8*g +: 8] : 8'h00;
  end
endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sram_cyc_pkg::*;
#(
  parameter int unsigned AW        = 29,
  parameter logic [2:0]  AREA_CODE = 3'b110,
  parameter int unsigned MAX_WAIT  = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic [31:0]   req_wdata_i,
  input  logic [3:0]    req_be_i,
  input  logic          req_write_i,
  input  logic [1:0]    cfg_width_i,
  input  logic [2:0]    cfg_setup_i,
  input  logic [2:0]    cfg_hold_i,
  input  logic [4:0]    cfg_wait_i,
  input  logic          cfg_bs_hold_i,
  input  logic          ext_ready_i,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic [3:0]    we_n_o,
  output logic          bs_n_o,
  output logic [AW-1:0] addr_o,
  output logic [31:0]   data_o,
  output logic          data_oe_o,
  input  logic [31:0]   data_i,
  output logic [31:0]   rsp_rdata_o,
  output logic          rsp_done_o
);
  localparam int unsigned CW = 5;

  phase_e        phase;
  area_cfg_t     cfg_d, cfg_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rdata_q, rdata_lane;
  logic [3:0]    be_q;
  logic          write_q, idle, accept, capture, bs_active;

  assign idle   = (phase == PH_IDLE);
  assign accept = req_valid_i && idle && (req_addr_i[28:26] == AREA_CODE);

  always_comb begin
    cfg_d.width   = cfg_width_i;
    cfg_d.setup   = cfg_setup_i;
    cfg_d.hold    = cfg_hold_i;
    cfg_d.waits   = (cfg_wait_i > 5'(MAX_WAIT)) ? 5'(MAX_WAIT) : cfg_wait_i;
    cfg_d.bs_hold = cfg_bs_hold_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      write_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        cfg_q   <= cfg_d;
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        be_q    <= req_be_i;
        write_q <= req_write_i;
      end
      if (capture && !write_q) rdata_q <= rdata_lane;
    end
  end

  sram_cyc_seq #(.CW(CW), .MAX_WAIT(MAX_WAIT)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (accept),
    .start_setup_i  (cfg_d.setup),
    .start_bs_hold_i(cfg_d.bs_hold),
    .start_waits_i  (cfg_d.waits),
    .waits_q_i      (cfg_q.waits),
    .hold_q_i       (cfg_q.hold),
    .ext_ready_i    (ext_ready_i),
    .phase_o        (phase),
    .capture_o      (capture),
    .bs_active_o    (bs_active),
    .done_o         (rsp_done_o)
  );

  sram_cyc_lanes u_lanes (
    .phase_i   (phase),
    .write_i   (write_q),
    .be_i      (be_q),
    .width_i   (cfg_q.width),
    .pin_data_i(data_i),
    .rd_n_o    (rd_n_o),
    .we_n_o    (we_n_o),
    .rdata_o   (rdata_lane)
  );

  assign req_ready_o = idle;
  assign cs_n_o      = idle;
  assign bs_n_o      = !bs_active;
  assign addr_o      = addr_q;
  assign data_o      = wdata_q;
  assign data_oe_o   = write_q && !idle;
  assign rsp_rdata_o = rdata_q;

  p_idle_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> (rd_n_o && we_n_o == 4'hF && bs_n_o));
  p_rd_we_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_n_o |-> (we_n_o == 4'hF));
  p_bs_in_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bs_n_o |-> !cs_n_o);
  p_cfg_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> (idle || $stable(cfg_q)));
  p_area_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && req_valid_i && req_addr_i[28:26] != AREA_CODE) |=> cs_n_o);
endmodule

// File: tb/sram_cycle_gen_tb.sv
module sram_cycle_gen_tb_top;
  localparam int unsigned AW = 29;
  localparam logic [2:0] AREA = 3'b110;

  typedef struct packed {
    logic        wr;
    logic [1:0]  width;
    logic [2:0]  setup;
    logic [2:0]  hold;
    logic [4:0]  waits;
    logic        bsh;
    logic [2:0]  ext;
    logic [3:0]  be;
    logic [31:0] data;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 3'd0, 3'd0, 5'd0,  1'b0, 3'd0, 4'hF, 32'hA1B2C3D4},
    '{1'b1, 2'd2, 3'd2, 3'd1, 5'd3,  1'b1, 3'd0, 4'h5, 32'h11223344},
    '{1'b0, 2'd1, 3'd1, 3'd2, 5'd2,  1'b1, 3'd2, 4'h3, 32'hCAFEF00D},
    '{1'b0, 2'd0, 3'd7, 3'd7, 5'd0,  1'b0, 3'd3, 4'h1, 32'h5A5A5A5A},
    '{1'b1, 2'd0, 3'd0, 3'd3, 5'd1,  1'b1, 3'd1, 4'hF, 32'h000000EE},
    '{1'b1, 2'd1, 3'd3, 3'd0, 5'd25, 1'b0, 3'd0, 4'hF, 32'hDEADBEEF},
    '{1'b0, 2'd3, 3'd0, 3'd0, 5'd31, 1'b0, 3'd1, 4'hF, 32'h13579BDF},
    '{1'b1, 2'd2, 3'd7, 3'd7, 5'd5,  1'b1, 3'd4, 4'hA, 32'h0F0F1234}
  };

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_valid_i = 1'b0, req_ready_o, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0, addr_o;
  logic [31:0]   req_wdata_i = '0, data_o, data_i = '0, rsp_rdata_o;
  logic [3:0]    req_be_i = '0, we_n_o;
  logic [1:0]    cfg_width_i = '0;
  logic [2:0]    cfg_setup_i = '0, cfg_hold_i = '0;
  logic [4:0]    cfg_wait_i = '0;
  logic          cfg_bs_hold_i = 1'b0, ext_ready_i = 1'b1;
  logic          cs_n_o, rd_n_o, bs_n_o, data_oe_o, rsp_done_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk_i = ~clk_i;

  sram_cycle_gen #(.AW(AW), .AREA_CODE(AREA)) dut_i (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] mask_of(input logic [1:0] w);
    return (w == 2'd0) ? 4'b0001 : (w == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  task automatic run_vec(input vec_t v, input bit scramble, input string tag);
    int c = 0, cs_cnt = 0, st_cnt = 0, st_first = 0, bs_cnt = 0, bs_first = 0;
    int nrdy = 0, done_at = 0, w, st_exp, done_exp;
    logic [3:0]  we_seen = 4'hF, we_exp;
    logic [31:0] rdval, mexp;
    bit data_ok = 1'b1;
    w        = (v.waits > 25) ? 25 : int'(v.waits);
    st_exp   = 1 + w + ((w != 0) ? int'(v.ext) : 0);
    done_exp = int'(v.setup) + st_exp + int'(v.hold) + 1;
    rdval    = v.data ^ 32'h5AA5_0FF0;
    for (int b = 0; b < 4; b++) mexp[8*b +: 8] = mask_of(v.width)[b] ? 8'hFF : 8'h00;
    we_exp   = v.wr ? ~(v.be & mask_of(v.width)) : 4'hF;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = v.wr; req_be_i = v.be; req_wdata_i = v.data;
    req_addr_i = {AREA, 26'(v.data)};
    cfg_width_i = v.width; cfg_setup_i = v.setup; cfg_hold_i = v.hold;
    cfg_wait_i = v.waits; cfg_bs_hold_i = v.bsh; data_i = rdval; ext_ready_i = 1'b0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (scramble) begin
      cfg_width_i = 2'd0; cfg_setup_i = 3'd0; cfg_hold_i = 3'd0;
      cfg_wait_i = 5'd0; cfg_bs_hold_i = 1'b0;
    end
    while (done_at == 0 && c < 300) begin
      c++;
      if (rsp_done_o) done_at = c;
      if (!cs_n_o) cs_cnt++;
      if (!req_ready_o) nrdy++;
      if (!bs_n_o) begin bs_cnt++; if (bs_first == 0) bs_first = c; end
      if (!rd_n_o || we_n_o != 4'hF) begin
        st_cnt++;
        if (st_first == 0) st_first = c;
        we_seen = we_n_o;
      end
      if (v.wr && !cs_n_o && (!data_oe_o || data_o != v.data)) data_ok = 1'b0;
      ext_ready_i = (!rd_n_o || we_n_o != 4'hF) && (st_cnt >= 1 + w + int'(v.ext));
      if (done_at == 0) @(negedge clk_i);
    end
    check(done_at == done_exp, {tag, " R10 done cycle"}, done_at, done_exp);
    check(cs_cnt == done_exp - 1, {tag, " R3/R7 cs length"}, cs_cnt, done_exp - 1);
    check(nrdy == done_exp - 1, {tag, " R3 ready low"}, nrdy, done_exp - 1);
    check(st_first == int'(v.setup) + 1, {tag, " R4 strobe start"}, st_first, v.setup + 1);
    check(st_cnt == st_exp, {tag, " R5/R6 strobe length"}, st_cnt, st_exp);
    check(bs_first == 1, {tag, " R8 bs start"}, bs_first, 1);
    check(bs_cnt == ((v.bsh && v.setup != 0) ? 2 : 1), {tag, " R8 bs length"}, bs_cnt,
          (v.bsh && v.setup != 0) ? 2 : 1);
    check(we_seen == we_exp, {tag, " R4 lanes"}, we_seen, we_exp);
    if (v.wr) check(data_ok, {tag, " R9 write data"}, data_o, v.data);
    else      check(rsp_rdata_o == (rdval & mexp), {tag, " R9 read data"}, rsp_rdata_o, rdval & mexp);
    @(negedge clk_i);
    check(!rsp_done_o, {tag, " R10 single pulse"}, rsp_done_o, 0);
    ext_ready_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(cs_n_o && rd_n_o && bs_n_o && we_n_o == 4'hF, "R1 strobes idle",
          {cs_n_o, rd_n_o, bs_n_o, we_n_o}, 7'h7F);
    check(!rsp_done_o && req_ready_o, "R1 ready/done", {rsp_done_o, req_ready_o}, 2'b01);
    // R2: foreign area code must be ignored
    req_valid_i = 1'b1; req_addr_i = {3'b101, 26'h0123};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      check(cs_n_o && !rsp_done_o, "R2 foreign area ignored", {cs_n_o, rsp_done_o}, 2'b10);
    end
    req_valid_i = 1'b0;
    foreach (VECS[i]) run_vec(VECS[i], 1'b0, $sformatf("vec%0d", i));
    run_vec(VECS[7], 1'b1, "R11 scrambled cfg");
    run_vec(VECS[2], 1'b1, "R11 scrambled narrow read");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule